// File: doc/BRIEF.md
# Coherent Byte-Access Channel Value Register

This block holds the 16-bit value of one timer channel and lets an 8-bit bus reach it one byte at a time without tearing. In capture mode a strobe copies a free-running count into the register. Software then reads the two halves in two separate accesses. The first read freezes a snapshot of the whole value, so later captures cannot split the pair.

In compare or PWM mode, software writes the two halves separately. Each byte waits in a staging buffer, and the register changes only when both halves are present. The new 16-bit value then lands in a single cycle, and a one-cycle pulse marks that cycle. The halves may be written in either order. A write to the channel's status/control register drops any half-finished read or write.

The counter, compare matching and pin generation sit outside the block. It only supplies the committed value to them.

Top module: `cvr_chan_value`

## Requirements
- R1: After reset, `value_o` is 0x0000, `commit_o` is 0, and neither the read latch nor the write staging holds anything.
- R2: In capture mode (`mode_cmp_i`=0), a cycle with `cap_i`=1 loads `cnt_i` into the register, and `value_o` shows it from the next clock edge. In compare mode (`mode_cmp_i`=1), `cap_i` has no effect.
- R3: In capture mode, the first byte read of a pair returns the live byte. `rd_hi_i`=1 selects bits 15:8 and `rd_hi_i`=0 selects bits 7:0. That first read freezes a copy of all 16 bits. A following read of the other byte returns that byte from the frozen copy and releases the latch. This works for either byte order.
- R4: While the read latch is held, a capture still updates `value_o`, but the read of the other byte returns the frozen value.
- R5: While the read latch is held, reading the same byte again returns the frozen byte and keeps the latch held.
- R6: In compare mode, a byte write (`wr_hi_i` selecting the half as in R3) leaves `value_o` unchanged until the other half is written. The value then becomes {high byte, low byte}, with the same result whichever half came first.
- R7: Writing the same half twice before its partner replaces the staged byte and does not commit.
- R8: `commit_o` is high for exactly one cycle: the first cycle in which `value_o` shows a value completed by a byte write.
- R9: A cycle with `ctl_wr_i`=1 clears the read latch and the write staging. A byte write made in that same cycle is discarded.
- R10: In compare mode, reads return live bytes and never latch. In capture mode, byte writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_cmp_i | input | 1 | 0 = capture mode, 1 = compare/PWM mode |
| cap_i | input | 1 | Capture strobe |
| cnt_i | input | 16 | Free-running counter value |
| rd_en_i | input | 1 | Byte read access |
| rd_hi_i | input | 1 | Read byte select (1 = bits 15:8) |
| rd_data_o | output | 8 | Read data, valid in the cycle of the access |
| wr_en_i | input | 1 | Byte write access |
| wr_hi_i | input | 1 | Write byte select (1 = bits 15:8) |
| wr_data_i | input | 8 | Write data |
| ctl_wr_i | input | 1 | Status/control register write strobe |
| value_o | output | 16 | Committed channel value |
| commit_o | output | 1 | One-cycle pulse on a write commit |

## Verification
Read pairs are issued in both byte orders, and one pair has a capture placed between its two reads. Only that case tells a frozen snapshot apart from a live read. A repeated same-byte read surrounds a capture to show that the latch stays held.

Write pairs are issued high-first and low-first, and both must give the same value. A doubled write to one half shows that the later byte wins without a commit. Control-register writes are placed mid-pair, and also in the same cycle as a byte write, to show that stale halves are dropped. Cross-mode accesses confirm that captures are ignored in compare mode and writes are ignored in capture mode.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

    parameter int unsigned CVR_BYTE_W = 8;

    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } byte_sel_e;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_COMPARE = 1'b1
    } chan_mode_e;

endpackage

// File: rtl/cvr_read_latch.sv
module cvr_read_latch
    import cvr_pkg::*;
#(
    parameter int unsigned BYTE_W = CVR_BYTE_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic                rd_en_i,
    input  logic                rd_hi_i,
    input  logic                clear_i,
    input  logic [2*BYTE_W-1:0] live_i,
    output logic [BYTE_W-1:0]   rd_data_o,
    output logic                held_o,
    output logic [2*BYTE_W-1:0] snap_o
);

    localparam int unsigned VAL_W = 2 * BYTE_W;

    typedef struct packed {
        logic             held;
        logic             first_hi;
        logic [VAL_W-1:0] snap;
    } rd_state_t;

    rd_state_t state_d, state_q;
    logic [VAL_W-1:0] src;

    always_comb begin
        state_d = state_q;
        if (clear_i || !enable_i) begin
            state_d.held = 1'b0;
        end else if (rd_en_i) begin
            if (!state_q.held) begin
                state_d.held     = 1'b1;
                state_d.first_hi = rd_hi_i;
                state_d.snap     = live_i;
            end else if (rd_hi_i != state_q.first_hi) begin
                state_d.held = 1'b0;
            end
        end
    end

    always_comb begin
        src = (state_q.held && enable_i) ? state_q.snap : live_i;
        if (rd_hi_i == BYTE_HI) begin
            rd_data_o = src[VAL_W-1:BYTE_W];
        end else begin
            rd_data_o = src[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign held_o = state_q.held;
    assign snap_o = state_q.snap;

endmodule

// File: rtl/cvr_write_stage.sv
module cvr_write_stage
    import cvr_pkg::*;
#(
    parameter int unsigned BYTE_W = CVR_BYTE_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic                wr_en_i,
    input  logic                wr_hi_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic                clear_i,
    output logic                load_o,
    output logic [2*BYTE_W-1:0] load_val_o,
    output logic                staged_o
);

    typedef struct packed {
        logic              have_hi;
        logic              have_lo;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } wr_state_t;

    wr_state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = {state_q.hi, state_q.lo};
        if (clear_i || !enable_i) begin
            state_d.have_hi = 1'b0;
            state_d.have_lo = 1'b0;
        end else if (wr_en_i) begin
            if (wr_hi_i == BYTE_HI) begin
                if (state_q.have_lo) begin
                    load_o          = 1'b1;
                    load_val_o      = {wr_data_i, state_q.lo};
                    state_d.have_lo = 1'b0;
                    state_d.have_hi = 1'b0;
                end else begin
                    state_d.hi      = wr_data_i;
                    state_d.have_hi = 1'b1;
                end
            end else begin
                if (state_q.have_hi) begin
                    load_o          = 1'b1;
                    load_val_o      = {state_q.hi, wr_data_i};
                    state_d.have_lo = 1'b0;
                    state_d.have_hi = 1'b0;
                end else begin
                    state_d.lo      = wr_data_i;
                    state_d.have_lo = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign staged_o = state_q.have_hi | state_q.have_lo;

endmodule

// File: rtl/cvr_value_reg.sv
module cvr_value_reg #(
    parameter int unsigned VAL_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_load_i,
    input  logic [VAL_W-1:0] cap_val_i,
    input  logic             wr_load_i,
    input  logic [VAL_W-1:0] wr_val_i,
    output logic [VAL_W-1:0] value_o,
    output logic             commit_o
);

    typedef struct packed {
        logic [VAL_W-1:0] value;
        logic             commit;
    } val_state_t;

    val_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.commit = 1'b0;
        if (wr_load_i) begin
            state_d.value  = wr_val_i;
            state_d.commit = 1'b1;
        end else if (cap_load_i) begin
            state_d.value = cap_val_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign value_o  = state_q.value;
    assign commit_o = state_q.commit;

endmodule

// File: rtl/cvr_chan_value.sv
module cvr_chan_value
    import cvr_pkg::*;
#(
    parameter int unsigned BYTE_W = CVR_BYTE_W,
    localparam int unsigned VAL_W = 2 * BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_cmp_i,
    input  logic              cap_i,
    input  logic [VAL_W-1:0]  cnt_i,
    input  logic              rd_en_i,
    input  logic              rd_hi_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              ctl_wr_i,
    output logic [VAL_W-1:0]  value_o,
    output logic              commit_o
);

    logic             in_capture;
    logic             in_compare;
    logic             rd_held;
    logic [VAL_W-1:0] rd_snap;
    logic             wr_load;
    logic [VAL_W-1:0] wr_val;
    logic             wr_staged;

    assign in_compare = (mode_cmp_i == MODE_COMPARE);
    assign in_capture = !in_compare;

    cvr_read_latch #(.BYTE_W(BYTE_W)) u_rd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (in_capture),
        .rd_en_i   (rd_en_i),
        .rd_hi_i   (rd_hi_i),
        .clear_i   (ctl_wr_i),
        .live_i    (value_o),
        .rd_data_o (rd_data_o),
        .held_o    (rd_held),
        .snap_o    (rd_snap)
    );

    cvr_write_stage #(.BYTE_W(BYTE_W)) u_wr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (in_compare),
        .wr_en_i    (wr_en_i),
        .wr_hi_i    (wr_hi_i),
        .wr_data_i  (wr_data_i),
        .clear_i    (ctl_wr_i),
        .load_o     (wr_load),
        .load_val_o (wr_val),
        .staged_o   (wr_staged)
    );

    cvr_value_reg #(.VAL_W(VAL_W)) u_val (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_load_i (cap_i && in_capture),
        .cap_val_i  (cnt_i),
        .wr_load_i  (wr_load),
        .wr_val_i   (wr_val),
        .value_o    (value_o),
        .commit_o   (commit_o)
    );

endmodule

// File: rtl/cvr_chan_value_chk.sv
module cvr_chan_value_chk #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned VAL_W = 2 * BYTE_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mode_cmp_i,
    input logic             cap_i,
    input logic [VAL_W-1:0] cnt_i,
    input logic             rd_en_i,
    input logic             ctl_wr_i,
    input logic [VAL_W-1:0] value_o,
    input logic             commit_o,
    input logic             rd_held,
    input logic [VAL_W-1:0] rd_snap,
    input logic             wr_staged
);

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (value_o == '0 && !commit_o && !rd_held && !wr_staged)); // R1

    AST_CAPTURE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_cmp_i && cap_i) |=> (value_o == $past(cnt_i))); // R2

    AST_SNAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_held && !mode_cmp_i && !ctl_wr_i && !rd_en_i) |=> (rd_held && $stable(rd_snap))); // R4

    AST_COMPARE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode_cmp_i) && !commit_o) |-> $stable(value_o)); // R6

    AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |=> !commit_o); // R8

    AST_CTL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_wr_i |=> (!rd_held && !wr_staged)); // R9

endmodule

bind cvr_chan_value cvr_chan_value_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_cmp_i (mode_cmp_i),
    .cap_i      (cap_i),
    .cnt_i      (cnt_i),
    .rd_en_i    (rd_en_i),
    .ctl_wr_i   (ctl_wr_i),
    .value_o    (value_o),
    .commit_o   (commit_o),
    .rd_held    (rd_held),
    .rd_snap    (rd_snap),
    .wr_staged  (wr_staged)
);

// File: tb/cvr_chan_value_bench.sv
module cvr_chan_value_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_cmp = 1'b0;
    logic        cap = 1'b0;
    logic [15:0] cnt = '0;
    logic        rd_en = 1'b0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ctl_wr = 1'b0;
    logic [15:0] value;
    logic        commit;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    typedef enum int { K_VAL, K_RD, K_COM } kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    cvr_chan_value u_cvr_chan_value (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_cmp_i (mode_cmp),
        .cap_i      (cap),
        .cnt_i      (cnt),
        .rd_en_i    (rd_en),
        .rd_hi_i    (rd_hi),
        .rd_data_o  (rd_data),
        .wr_en_i    (wr_en),
        .wr_hi_i    (wr_hi),
        .wr_data_i  (wr_data),
        .ctl_wr_i   (ctl_wr),
        .value_o    (value),
        .commit_o   (commit)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it = sb_q.pop_front();
            case (it.kind)
                K_VAL:   got = value;
                K_RD:    got = {8'h00, rd_data};
                default: got = {15'h0, commit};
            endcase
            n_checks++;
            if (got !== it.exp) begin
                n_fails++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
            end
        end
    end

    function automatic void push(kind_e k, logic [15:0] e, string r);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.req  = r;
        sb_q.push_back(it);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        cap = 1'b0; rd_en = 1'b0; wr_en = 1'b0; ctl_wr = 1'b0;
    endtask

    task automatic idle();
        step();
    endtask

    task automatic do_cap(logic [15:0] v);
        step();
        cap = 1'b1; cnt = v;
    endtask

    task automatic do_rd(logic hi, logic [7:0] e, string r);
        step();
        rd_en = 1'b1; rd_hi = hi;
        push(K_RD, {8'h00, e}, r);
    endtask

    task automatic do_wr(logic hi, logic [7:0] d, logic with_ctl);
        step();
        wr_en = 1'b1; wr_hi = hi; wr_data = d; ctl_wr = with_ctl;
    endtask

    task automatic do_ctl();
        step();
        ctl_wr = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        push(K_VAL, 16'h0000, "R1");
        push(K_COM, 16'h0000, "R1");

        // capture mode
        do_cap(16'h1234); idle();
        push(K_VAL, 16'h1234, "R2");
        do_rd(1'b1, 8'h12, "R3");
        do_cap(16'hABCD); idle();
        push(K_VAL, 16'hABCD, "R4");
        do_rd(1'b0, 8'h34, "R4");
        do_rd(1'b0, 8'hCD, "R3");
        do_rd(1'b1, 8'hAB, "R3");
        do_rd(1'b1, 8'hAB, "R5");
        do_cap(16'h5566); idle();
        do_rd(1'b1, 8'hAB, "R5");
        do_rd(1'b0, 8'hCD, "R5");
        do_rd(1'b1, 8'h55, "R9");
        do_ctl();
        do_cap(16'h7788); idle();
        do_rd(1'b0, 8'h88, "R9");
        do_rd(1'b1, 8'h77, "R9");
        do_wr(1'b1, 8'hEE, 1'b0);
        do_wr(1'b0, 8'hFF, 1'b0);
        idle();
        push(K_VAL, 16'h7788, "R10");
        push(K_COM, 16'h0000, "R10");

        // compare mode
        step(); mode_cmp = 1'b1;
        do_cap(16'h9999); idle();
        push(K_VAL, 16'h7788, "R2");
        do_wr(1'b1, 8'h12, 1'b0); idle();
        push(K_VAL, 16'h7788, "R6");
        push(K_COM, 16'h0000, "R6");
        do_wr(1'b0, 8'h34, 1'b0); idle();
        push(K_VAL, 16'h1234, "R6");
        push(K_COM, 16'h0001, "R8");
        idle();
        push(K_COM, 16'h0000, "R8");
        do_wr(1'b0, 8'hCD, 1'b0);
        do_wr(1'b1, 8'hAB, 1'b0); idle();
        push(K_VAL, 16'hABCD, "R6");
        push(K_COM, 16'h0001, "R8");
        do_wr(1'b1, 8'h11, 1'b0);
        do_wr(1'b1, 8'h22, 1'b0); idle();
        push(K_VAL, 16'hABCD, "R7");
        push(K_COM, 16'h0000, "R7");
        do_wr(1'b0, 8'h33, 1'b0); idle();
        push(K_VAL, 16'h2233, "R7");
        do_wr(1'b1, 8'h44, 1'b0);
        do_ctl();
        do_wr(1'b0, 8'h55, 1'b0); idle();
        push(K_VAL, 16'h2233, "R9");
        do_wr(1'b1, 8'h66, 1'b0); idle();
        push(K_VAL, 16'h6655, "R9");
        do_wr(1'b0, 8'h77, 1'b1);
        do_wr(1'b1, 8'h88, 1'b0); idle();
        push(K_VAL, 16'h6655, "R9");
        do_wr(1'b0, 8'h99, 1'b0); idle();
        push(K_VAL, 16'h8899, "R9");
        do_rd(1'b1, 8'h88, "R10");
        do_wr(1'b1, 8'h01, 1'b0);
        do_wr(1'b0, 8'h02, 1'b0); idle();
        do_rd(1'b0, 8'h02, "R10");
        idle();
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule